// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block turns pending interrupt requests into a timed exception entry. Each request line belongs to one of three source classes, fixed by its position. Line 0 is the non-maskable source. The next `N_PER` lines are on-chip peripherals, and the remaining lines are external request pins. Every line carries a priority level and a vector number.

When the sequencer is idle, it picks one winning request, raises a one-cycle take pulse and then judges the request. A request that is enabled for transfer activation, and whose source can be activated that way, is handed to the transfer engine with a pulse and never touches the bus. Any other request goes through a priority stage whose length depends on its class. The sequencer then waits for the processor to report that its current sequence is done. Finally it runs four longword bus accesses in order: the status word is pushed, the program counter is pushed, the vector slot is read, and the first handler instruction is fetched.

Every access holds its address and strobe until the memory returns ready, so wait states stretch the entry. The block counts the states it spends from acceptance to the fetch issue, and presents that count together with a done pulse.

Top module: `iesq_top`

## Requirements
- R1: After synchronous reset, `take`, `dma_go`, `done` and `mem_req` are low, and `lat_states` is 0.
- R2: A request is accepted only if its 4-bit level is strictly greater than `sr_mask`. A request whose level equals the mask is never taken. Source 0 is accepted at any level and any mask.
- R3: Among eligible requests, source 0 wins over all others. Otherwise the highest level wins, and on equal levels the lowest index wins.
- R4: A winning source with its `dma_en` bit set is routed to the transfer engine if it is capable of transfer activation. External sources (index above `N_PER`) are always capable; peripheral source i is capable when bit i-1 of `PER_CAP` is set. The route raises `dma_go` together with `take` in the cycle after acceptance and performs no bus access.
- R5: The judgment length L, counted from the acceptance cycle, is 2 for source 0. For a peripheral it is 2, or 3 if the peripheral is transfer-capable. For an external source it is 4.
- R6: Once judgment ends, the sequencer waits X states, where X is the number of states during which `cpu_done` was sampled low after judgment. X is 0 if `cpu_done` is high at the end of judgment.
- R7: The bus accesses run in this order. First, a write of `sr_word` to `sp_word`-4. Second, a write of `pc_word` to `sp_word`-8. Third, a read at `vbase` + 4 × vector number. Fourth, an instruction read at the address returned by that vector read.
- R8: Each access keeps `mem_req`, `mem_we` and `mem_addr` steady until `mem_ready` is sampled high. An access that sees ready in its m-th state lasts m states. Exception processing, up to the fetch issue, takes 5 + m1 + m2 + m3 states.
- R9: `done` is a one-cycle pulse in the first state of the instruction fetch. This state comes T = L + X + 5 + m1 + m2 + m3 states after the acceptance cycle, and `lat_states` then reads T.
- R10: `take` pulses for one cycle in the cycle after acceptance, with `take_idx` giving the winning source. While an entry is in progress, no further request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N_SRC | Request lines, index 0 non-maskable |
| irq_lvl | input | N_SRC*LVL_W | Priority level per line |
| irq_vec | input | N_SRC*VEC_W | Vector number per line |
| dma_en | input | N_SRC | Per-line request to route to the transfer engine |
| sr_mask | input | LVL_W | Current interrupt mask level |
| sr_word | input | DW | Status word to save |
| pc_word | input | DW | Program counter to save |
| sp_word | input | AW | Stack pointer before the entry |
| vbase | input | AW | Vector table base address |
| cpu_done | input | 1 | Processor has finished its current sequence |
| mem_req | output | 1 | Bus access strobe |
| mem_we | output | 1 | Bus access is a write |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Bus write data |
| mem_rdata | input | DW | Bus read data |
| mem_ready | input | 1 | Access completes in this state |
| take | output | 1 | Request accepted (one cycle) |
| take_idx | output | $clog2(N_SRC) | Index of the accepted source |
| dma_go | output | 1 | Transfer-engine activation pulse |
| done | output | 1 | First instruction fetch issued |
| lat_states | output | CNT_W | States from acceptance to fetch issue |

## Verification
The bench drives a request at a falling edge and counts falling edges from that point. It samples `take` and `dma_go` exactly one edge later. It samples `done` exactly T edges later, and it computes T from the class length, the chosen wait X and the ready delay configured for each access. To produce X, the bench raises `cpu_done` exactly L+X-1 edges after the request. Its memory model answers ready after a set number of states for each access and records the address and data it sees, so the order and values of the four accesses are compared once the fetch completes. Idle checks watch `take` and `mem_req` over a window several states long.

// File: rtl/iesq_pkg.sv
package iesq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_JUDGE,
        ST_WAIT,
        ST_PREP,
        ST_SRW,
        ST_G1,
        ST_PCW,
        ST_G2,
        ST_VRD,
        ST_G3,
        ST_FETCH
    } st_e;

    typedef enum logic [1:0] {
        CL_NMI,
        CL_PER,
        CL_EXT
    } cls_e;

    // internal states before the first push; three gap states follow the first three accesses
    localparam int PREP_N = 2;

    function automatic cls_e cls_of(input int idx, input int nper);
        if (idx == 0)        return CL_NMI;
        else if (idx <= nper) return CL_PER;
        else                 return CL_EXT;
    endfunction

    function automatic logic dma_capable(input int idx, input int nper, input logic [31:0] capmask);
        case (cls_of(idx, nper))
            CL_NMI:  return 1'b0;
            CL_PER:  return capmask[(idx > 0) ? idx - 1 : 0];
            default: return 1'b1;
        endcase
    endfunction

    // activation judgment (0/1) plus priority judgment (2 or 3)
    function automatic int judge_states(input int idx, input int nper, input logic [31:0] capmask);
        int j;
        j = dma_capable(idx, nper, capmask) ? 1 : 0;
        j += (cls_of(idx, nper) == CL_EXT) ? 3 : 2;
        return j;
    endfunction

endpackage

// File: rtl/iesq_arb.sv
module iesq_arb #(
    parameter int N_SRC = 6,
    parameter int LVL_W = 4,
    localparam int IW   = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]       req,
    input  logic [N_SRC*LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0]       mask,
    output logic                   win_v,
    output logic [IW-1:0]          win_idx
);
    logic [LVL_W:0] best;
    logic [LVL_W:0] eff;
    logic           elig;

    always_comb begin
        win_v   = 1'b0;
        win_idx = '0;
        best    = '0;
        eff     = '0;
        elig    = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            // source 0 ranks above every maskable level
            eff  = {(i == 0), lvl[i*LVL_W +: LVL_W]};
            elig = req[i] && ((i == 0) || (lvl[i*LVL_W +: LVL_W] > mask));
            if (elig && (!win_v || eff > best)) begin
                win_v   = 1'b1;
                best    = eff;
                win_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/iesq_bus.sv
module iesq_bus
    import iesq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int VEC_W = 8
) (
    input  st_e              st,
    input  logic [AW-1:0]    sp,
    input  logic [DW-1:0]    sr,
    input  logic [DW-1:0]    pc,
    input  logic [AW-1:0]    vbase,
    input  logic [VEC_W-1:0] vec,
    input  logic [AW-1:0]    handler,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata
);
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            ST_SRW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp - AW'(4);
                mem_wdata = sr;
            end
            ST_PCW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp - AW'(8);
                mem_wdata = pc;
            end
            ST_VRD: begin
                mem_req  = 1'b1;
                mem_addr = vbase + AW'({vec, 2'b00});
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = handler;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/iesq_lat.sv
module iesq_lat #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CNT_W'(1);
        else if (run && cnt != '1)
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/iesq_top.sv
module iesq_top
    import iesq_pkg::*;
#(
    parameter int          N_SRC   = 6,
    parameter int          N_PER   = 2,
    parameter logic [31:0] PER_CAP = 32'b10,
    parameter int          LVL_W   = 4,
    parameter int          VEC_W   = 8,
    parameter int          AW      = 32,
    parameter int          DW      = 32,
    parameter int          CNT_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_SRC-1:0]           irq_req,
    input  logic [N_SRC*LVL_W-1:0]     irq_lvl,
    input  logic [N_SRC*VEC_W-1:0]     irq_vec,
    input  logic [N_SRC-1:0]           dma_en,
    input  logic [LVL_W-1:0]           sr_mask,
    input  logic [DW-1:0]              sr_word,
    input  logic [DW-1:0]              pc_word,
    input  logic [AW-1:0]              sp_word,
    input  logic [AW-1:0]              vbase,
    input  logic                       cpu_done,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [AW-1:0]              mem_addr,
    output logic [DW-1:0]              mem_wdata,
    input  logic [DW-1:0]              mem_rdata,
    input  logic                       mem_ready,
    output logic                       take,
    output logic [$clog2(N_SRC)-1:0]   take_idx,
    output logic                       dma_go,
    output logic                       done,
    output logic [CNT_W-1:0]           lat_states
);
    localparam int IW = $clog2(N_SRC);

    logic [2:0]       jlen [N_SRC];
    logic [N_SRC-1:0] cap;

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_src
            assign jlen[g] = 3'(judge_states(g, N_PER, PER_CAP));
            assign cap[g]  = dma_capable(g, N_PER, PER_CAP);
        end
    endgenerate

    logic          win_v;
    logic [IW-1:0] win_idx;
    logic          route_dma;

    iesq_arb #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
        .req     (irq_req),
        .lvl     (irq_lvl),
        .mask    (sr_mask),
        .win_v   (win_v),
        .win_idx (win_idx)
    );

    st_e              st;
    logic [2:0]       dly;
    logic [IW-1:0]    idx_q;
    logic [VEC_W-1:0] vec_q;
    logic [LVL_W-1:0] lvl_q;
    logic [AW-1:0]    handler_q;

    assign route_dma = dma_en[win_idx] && cap[win_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            dly       <= '0;
            idx_q     <= '0;
            vec_q     <= '0;
            lvl_q     <= '0;
            handler_q <= '0;
            take      <= 1'b0;
            dma_go    <= 1'b0;
            done      <= 1'b0;
        end else begin
            take   <= 1'b0;
            dma_go <= 1'b0;
            done   <= 1'b0;
            case (st)
                ST_IDLE: if (win_v) begin
                    take  <= 1'b1;
                    idx_q <= win_idx;
                    vec_q <= irq_vec[win_idx*VEC_W +: VEC_W];
                    lvl_q <= irq_lvl[win_idx*LVL_W +: LVL_W];
                    if (route_dma) begin
                        dma_go <= 1'b1;
                    end else begin
                        st  <= ST_JUDGE;
                        dly <= jlen[win_idx] - 3'd2;
                    end
                end
                ST_JUDGE: begin
                    if (dly == '0) begin
                        st  <= cpu_done ? ST_PREP : ST_WAIT;
                        dly <= 3'(PREP_N - 1);
                    end else begin
                        dly <= dly - 3'd1;
                    end
                end
                ST_WAIT: if (cpu_done) begin
                    st  <= ST_PREP;
                    dly <= 3'(PREP_N - 1);
                end
                ST_PREP: begin
                    if (dly == '0) st <= ST_SRW;
                    else           dly <= dly - 3'd1;
                end
                ST_SRW:  if (mem_ready) st <= ST_G1;
                ST_G1:   st <= ST_PCW;
                ST_PCW:  if (mem_ready) st <= ST_G2;
                ST_G2:   st <= ST_VRD;
                ST_VRD: if (mem_ready) begin
                    handler_q <= AW'(mem_rdata);
                    st        <= ST_G3;
                end
                ST_G3: begin
                    st   <= ST_FETCH;
                    done <= 1'b1;
                end
                ST_FETCH: if (mem_ready) st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    assign take_idx = idx_q;

    iesq_bus #(.AW(AW), .DW(DW), .VEC_W(VEC_W)) u_bus (
        .st        (st),
        .sp        (sp_word),
        .sr        (sr_word),
        .pc        (pc_word),
        .vbase     (vbase),
        .vec       (vec_q),
        .handler   (handler_q),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    iesq_lat #(.CNT_W(CNT_W)) u_lat (
        .clk   (clk),
        .rst   (rst),
        .start (st == ST_IDLE && win_v && !route_dma),
        .run   (st != ST_IDLE && st != ST_FETCH),
        .cnt   (lat_states)
    );

    // R2: a maskable winner had a level above the mask of its acceptance cycle
    p_take_elig_r2: assert property (@(posedge clk) disable iff (rst)
        (take && take_idx != '0) |-> (lvl_q > $past(sr_mask)));

    // R4: transfer activation comes with a take and leaves the bus idle
    p_dma_nobus_r4: assert property (@(posedge clk) disable iff (rst)
        dma_go |-> (take && !mem_req));

    // R8: an unfinished access keeps its strobe, direction and address
    p_bus_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9: done marks an issued instruction read and lasts one cycle
    p_done_fetch_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (mem_req && !mem_we));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: no new take while an entry is running
    p_take_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        take |=> !take || $past(dma_go));
endmodule

// File: tb/tb_iesq_top.sv
module tb_iesq_top;
    localparam int N  = 6;
    localparam int LW = 4;
    localparam int VW = 8;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst;
    logic [N-1:0]      irq_req;
    logic [N*LW-1:0]   irq_lvl;
    logic [N*VW-1:0]   irq_vec;
    logic [N-1:0]      dma_en;
    logic [LW-1:0]     sr_mask;
    logic [DW-1:0]     sr_word, pc_word;
    logic [AW-1:0]     sp_word, vbase;
    logic              cpu_done;
    logic              mem_req, mem_we, mem_ready;
    logic [AW-1:0]     mem_addr;
    logic [DW-1:0]     mem_wdata, mem_rdata;
    logic              take, dma_go, done;
    logic [2:0]        take_idx;
    logic [CW-1:0]     lat_states;

    iesq_top dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_vec(irq_vec),
        .dma_en(dma_en), .sr_mask(sr_mask), .sr_word(sr_word), .pc_word(pc_word),
        .sp_word(sp_word), .vbase(vbase), .cpu_done(cpu_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .take(take), .take_idx(take_idx), .dma_go(dma_go), .done(done), .lat_states(lat_states)
    );

    int n_chk = 0;
    int n_bad = 0;

    int          mcfg [4];
    int          acc;
    int          mk;
    logic [31:0] rec_addr [4];
    logic        rec_we   [4];
    logic [31:0] rec_data [4];

    function automatic logic [31:0] hnd(input logic [31:0] a);
        return (a ^ 32'h00C3_0000) + 32'h0000_0100;
    endfunction

    // memory model: ready in the m-th state of each access
    always @(negedge clk) begin
        mem_rdata = hnd(mem_addr);
        if (rst || !mem_req) begin
            mk        = 0;
            mem_ready = 1'b0;
        end else begin
            mk++;
            if (acc < 4 && mk >= mcfg[acc]) begin
                mem_ready     = 1'b1;
                rec_addr[acc] = mem_addr;
                rec_we[acc]   = mem_we;
                rec_data[acc] = mem_wdata;
                acc++;
            end else begin
                mem_ready = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int lat_of(input int s);
        if (s <= 1) return 2;
        if (s == 2) return 3;
        return 4;
    endfunction

    function automatic logic [7:0] vec_of(input int s);
        return 8'(8'h20 + s * 5);
    endfunction

    task automatic run_cpu(input int s, input int lvl, input int x,
                           input int a, input int b, input int c, input int d);
        int L, T, n, w;
        bit got;
        logic [31:0] va;
        mcfg[0] = a; mcfg[1] = b; mcfg[2] = c; mcfg[3] = d;
        acc = 0;
        L = lat_of(s);
        T = L + x + 5 + a + b + c;
        @(negedge clk);
        cpu_done = (x == 0);
        irq_req  = '0;
        irq_req[s] = 1'b1;
        irq_lvl[s*LW +: LW] = LW'(lvl);
        n = 0;
        got = 1'b0;
        while (!got && n < 300) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                chk(take && !dma_go && take_idx == 3'(s), "R10 take/idx", {29'd0, take_idx}, s);
                irq_req = '0;
            end
            if (x > 0 && n == L + x - 1) cpu_done = 1'b1;
            if (done) got = 1'b1;
        end
        // done due T states after the acceptance state (R5 judge, R6 wait, R8 access lengths)
        chk(n == T, "R9 done timing", n, T);
        chk(lat_states == CW'(T), "R9 lat_states", {24'd0, lat_states}, T);
        w = 0;
        while (acc < 4 && w < 50) begin
            @(negedge clk);
            w++;
        end
        va = vbase + {22'd0, vec_of(s), 2'b00};
        chk(rec_addr[0] == sp_word - 4 && rec_we[0], "R7 sr push addr", rec_addr[0], sp_word - 4);
        chk(rec_data[0] == sr_word, "R7 sr push data", rec_data[0], sr_word);
        chk(rec_addr[1] == sp_word - 8 && rec_we[1], "R7 pc push addr", rec_addr[1], sp_word - 8);
        chk(rec_data[1] == pc_word, "R7 pc push data", rec_data[1], pc_word);
        chk(rec_addr[2] == va && !rec_we[2], "R7 vector read", rec_addr[2], va);
        chk(rec_addr[3] == hnd(va) && !rec_we[3], "R7 fetch addr", rec_addr[3], hnd(va));
        repeat (2) @(negedge clk);
        cpu_done = 1'b1;
    endtask

    task automatic run_dma(input int s);
        bit busy;
        acc = 0;
        @(negedge clk);
        irq_req = '0;
        irq_req[s] = 1'b1;
        irq_lvl[s*LW +: LW] = 4'd9;
        dma_en[s] = 1'b1;
        @(negedge clk);
        chk(dma_go && take && take_idx == 3'(s), "R4 dma route", {28'd0, dma_go, take_idx}, {28'd0, 1'b1, 3'(s)});
        irq_req = '0;
        dma_en  = '0;
        busy = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (mem_req || dma_go) busy = 1'b1;
        end
        chk(!busy && acc == 0, "R4 no bus after dma", {31'd0, busy}, 0);
    endtask

    task automatic prio(input logic [N-1:0] rq, input logic [N*LW-1:0] lv, input int exp);
        mcfg[0] = 1; mcfg[1] = 1; mcfg[2] = 1; mcfg[3] = 1;
        acc = 0;
        @(negedge clk);
        cpu_done = 1'b1;
        irq_lvl  = lv;
        irq_req  = rq;
        @(negedge clk);
        chk(take && take_idx == 3'(exp), "R3 winner", {29'd0, take_idx}, exp);
        irq_req = '0;
        repeat (30) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        bit seen;
        rst = 1'b1;
        irq_req = '0; irq_lvl = '0; dma_en = '0; sr_mask = 4'd3;
        for (int s = 0; s < N; s++) irq_vec[s*VW +: VW] = vec_of(s);
        sr_word = 32'h0000_00F0; pc_word = 32'h0000_1236;
        sp_word = 32'h0010_0100; vbase = 32'h0000_8000;
        cpu_done = 1'b1;
        acc = 0; mk = 0;
        mcfg[0] = 1; mcfg[1] = 1; mcfg[2] = 1; mcfg[3] = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!take && !dma_go && !done && !mem_req && lat_states == 0, "R1 reset state",
            {27'd0, take, dma_go, done, mem_req, |lat_states}, 0);

        // sweep of class, wait and access lengths
        for (int s = 0; s < N; s++)
            for (int xi = 0; xi < 3; xi++)
                for (int mp = 0; mp < 2; mp++) begin
                    int x;
                    x = (xi == 2) ? 3 : xi;
                    if (mp == 0) run_cpu(s, 4 + s, x, 1, 1, 1, 1);
                    else         run_cpu(s, 4 + s, x, 2, 1, 3, 2);
                end

        // R2: level equal to mask is ignored
        sr_mask = 4'd5;
        @(negedge clk);
        irq_lvl[4*LW +: LW] = 4'd5;
        irq_req = 6'b010000;
        seen = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (take || mem_req) seen = 1'b1;
        end
        chk(!seen, "R2 equal level ignored", {31'd0, seen}, 0);
        run_cpu(4, 6, 0, 1, 1, 1, 1);
        sr_mask = 4'd15;
        run_cpu(0, 0, 1, 1, 2, 1, 1);
        sr_mask = 4'd0;

        // R3 priority
        prio(6'b111000, {4'd9, 4'd9, 4'd7, 12'd0}, 4);
        prio(6'b010010, {8'd0, 4'd9, 8'd0, 4'd9, 4'd0}, 1);
        prio(6'b100001, {4'd15, 20'd0}, 0);
        prio(6'b001110, {12'd0, 4'd3, 4'd8, 4'd2, 4'd0}, 2);

        // R4 transfer routing; source 1 is not capable so it enters normally (R5: L=2)
        run_dma(2);
        run_dma(5);
        dma_en[1] = 1'b1;
        run_cpu(1, 7, 0, 1, 1, 1, 1);
        dma_en = '0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule